// File: doc/BRIEF.md
# 4-bit Accumulator Execution Unit

This block carries out the data-path instructions of a small 4-bit microcontroller. It holds a 4-bit accumulator, a 4-bit Y register, a 2-bit X register and a single status flag. It also owns a data memory of 64 four-bit words, addressed by the pair X:Y. Instruction fetch, program counter, branch and call handling, and the output port registers are supplied by neighbouring blocks.

A sequencer presents an 8-bit opcode together with `start` while the unit is idle. The unit samples the opcode and the four K input pins in that cycle. It reads memory, computes, and commits in a fixed three-cycle sequence. On commit it raises `done` for one cycle. For the output-port instructions it also raises a one-cycle strobe, with the operands that the port logic needs.

The status flag acts as a carry, as a no-borrow flag or as a comparison result, depending on the opcode. Every opcode that gives the flag no meaning forces it to 1. This includes the opcodes this unit does not act on, which are 0x0F, 0x10–0x1F and 0x80–0xFF.

Top module: `acc4_exec_unit`

## Requirements
- R1: While `rst` is high and after it is released, the accumulator, Y and X are 0, status is 1, and `busy`, `done` and all strobes are 0.
- R2: `start` is accepted only while `busy` is 0. `busy` is then high for the next two cycles. Register results and a one-cycle `done` appear after the third rising edge counted from acceptance. A `start` raised while busy is ignored. Registers change only in the cycle that shows `done`.
- R3: Memory is addressed by {X,Y}, with X as the upper 2 bits, giving 64 words. 0x03 stores A. 0x04 stores A and clears A. 0x21 loads A from memory. 0x22 loads Y from memory. 0x2E swaps A with memory. 0110iiii stores iiii and then increments Y, wrapping from 15 to 0.
- R4: Every opcode with no status result sets status to 1. This covers 0x0F, 0x10–0x1F and 0x80–0xFF, which change nothing else.
- R5: 0x01, 0x05 and 0x06 add 8, 10 and 6 to A. 0x0E adds 1 and forces status to 1. 0x25 sets A to A+mem. 0x28 sets A to mem+1. For all the additions except 0x0E, status is the carry out of bit 3.
- R6: 0x07 sets A to A−1. 0x27 sets A to mem−A. 0x2A sets A to mem−1. 0x2C sets Y to Y−1. Status is 1 when no borrow occurs, that is, when the minuend is greater than or equal to the subtrahend. 0x2D sets A to −A (mod 16), with status 1 exactly when A was 0.
- R7: Compares: 0x02 tests Y≠A. 0x26 tests mem≠0. 0x29 tests A≤mem. 0101iiii tests mem≠iiii. 0111iiii tests A≤iiii. The result goes to status.
- R8: 001100bb sets bit bb of mem[{X,Y}]. 001101bb clears bit bb. 001110bb copies bit bb to status. Bit 0 is the least significant bit.
- R9: 0x00 inverts X. 001111xx loads X with xx. 0100iiii loads Y with iiii. 0x23 copies Y into A. 0x24 copies A into Y. 0x2B increments Y, with status set to the carry. 0x20 stores A and increments Y. 0x2F clears A.
- R10: Each of these opcodes gives a one-cycle strobe together with `done`. 0x0A raises `tdo_stb`, with `o_data` set to the pre-instruction A and `o_seg_mode` set to the pre-instruction status. 0x0B raises `clo_stb`. 0x0C raises `r_clr_stb`. 0x0D raises `r_set_stb`. `r_index` carries Y.
- R11: 0x08 loads A from K. 0x09 sets status when any K pin is high. K is sampled only in the acceptance cycle, and later changes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opcode valid, taken when idle |
| opcode | input | 8 | Instruction to execute |
| k_pins | input | 4 | K input pins |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle commit pulse |
| acc | output | 4 | Accumulator |
| yreg | output | 4 | Y register |
| xreg | output | 2 | X register |
| status | output | 1 | Status flag |
| tdo_stb | output | 1 | Transfer-to-O strobe |
| o_data | output | 4 | Accumulator value for the O port |
| o_seg_mode | output | 1 | Status value selecting the O port decode |
| clo_stb | output | 1 | Clear-O strobe |
| r_set_stb | output | 1 | Set-R-line strobe |
| r_clr_stb | output | 1 | Clear-R-line strobe |
| r_index | output | 4 | R line selected (Y) |

## Verification
The first pattern fills all 64 words with a walk that steps X with the X-load opcodes and Y with the store-and-increment opcode. Any error in how the X:Y pair forms the address then shows up as a wrong value on later reads. Directed sequences place A, Y and memory on both sides of each carry and borrow boundary: A=8 plus 8, A=0 minus 1, Y=15 plus 1, and A equal to the immediate. These separate a 5-bit carry from a 4-bit wrap and "≤" from "<". A long stream of seeded random opcodes and K values follows. In this stream the bench changes K and pulses `start` again in the middle of each instruction, which shows whether the K sample point or the busy lockout is wrong.

// File: rtl/acc4_pkg.sv
package acc4_pkg;
  localparam int NYB_W  = 4;
  localparam int X_W    = 2;
  localparam int Y_W    = NYB_W;
  localparam int ADDR_W = X_W + Y_W;
  localparam int OP_W   = 8;

  typedef logic [NYB_W-1:0] nyb_t;
  typedef logic [X_W-1:0]   xr_t;

  typedef enum logic [1:0] {PH_IDLE, PH_EX, PH_WB} phase_t;

  typedef struct packed {
    nyb_t a;
    nyb_t y;
    xr_t  x;
    logic s;
    logic mem_we;
    nyb_t mem_d;
    logic tdo;
    logic clo;
    logic rset;
    logic rclr;
  } exec_res_t;
endpackage

// File: rtl/acc4_nyb_ram.sv
module acc4_nyb_ram #(
  parameter int AW = 6,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/acc4_alu.sv
module acc4_alu
  import acc4_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  nyb_t            a,
  input  nyb_t            y,
  input  xr_t             x,
  input  nyb_t            m,
  input  nyb_t            k,
  output exec_res_t       r
);
  logic [NYB_W:0] t;
  nyb_t           addk;
  nyb_t           bmask;
  nyb_t           imm;

  assign imm   = op[NYB_W-1:0];
  assign bmask = nyb_t'(1) << op[1:0];

  always_comb begin
    unique case (op[3:0])
      4'h1:    addk = 4'd8;
      4'h5:    addk = 4'd10;
      default: addk = 4'd6;
    endcase
  end

  always_comb begin
    r        = '0;
    r.a      = a;
    r.y      = y;
    r.x      = x;
    r.s      = 1'b1;
    r.mem_d  = m;
    t        = '0;
    casez (op)
      8'h00: r.x = ~x;
      8'h01, 8'h05, 8'h06: begin
        t   = {1'b0, a} + {1'b0, addk};
        r.a = t[NYB_W-1:0];
        r.s = t[NYB_W];
      end
      8'h02: r.s = (y != a);
      8'h03: begin r.mem_we = 1'b1; r.mem_d = a; end
      8'h04: begin r.mem_we = 1'b1; r.mem_d = a; r.a = '0; end
      8'h07: begin
        t   = {1'b0, a} - 5'd1;
        r.a = t[NYB_W-1:0];
        r.s = ~t[NYB_W];
      end
      8'h08: r.a = k;
      8'h09: r.s = (k != '0);
      8'h0a: r.tdo  = 1'b1;
      8'h0b: r.clo  = 1'b1;
      8'h0c: r.rclr = 1'b1;
      8'h0d: r.rset = 1'b1;
      8'h0e: r.a = a + 4'd1;
      8'h20: begin r.mem_we = 1'b1; r.mem_d = a; r.y = y + 4'd1; end
      8'h21: r.a = m;
      8'h22: r.y = m;
      8'h23: r.a = y;
      8'h24: r.y = a;
      8'h25: begin
        t   = {1'b0, a} + {1'b0, m};
        r.a = t[NYB_W-1:0];
        r.s = t[NYB_W];
      end
      8'h26: r.s = (m != '0);
      8'h27: begin
        t   = {1'b0, m} - {1'b0, a};
        r.a = t[NYB_W-1:0];
        r.s = ~t[NYB_W];
      end
      8'h28: begin
        t   = {1'b0, m} + 5'd1;
        r.a = t[NYB_W-1:0];
        r.s = t[NYB_W];
      end
      8'h29: r.s = (a <= m);
      8'h2a: begin
        t   = {1'b0, m} - 5'd1;
        r.a = t[NYB_W-1:0];
        r.s = ~t[NYB_W];
      end
      8'h2b: begin
        t   = {1'b0, y} + 5'd1;
        r.y = t[NYB_W-1:0];
        r.s = t[NYB_W];
      end
      8'h2c: begin
        t   = {1'b0, y} - 5'd1;
        r.y = t[NYB_W-1:0];
        r.s = ~t[NYB_W];
      end
      8'h2d: begin r.a = -a; r.s = (a == '0); end
      8'h2e: begin r.mem_we = 1'b1; r.mem_d = a; r.a = m; end
      8'h2f: r.a = '0;
      8'b0011_00??: begin r.mem_we = 1'b1; r.mem_d = m | bmask; end
      8'b0011_01??: begin r.mem_we = 1'b1; r.mem_d = m & ~bmask; end
      8'b0011_10??: r.s = |(m & bmask);
      8'b0011_11??: r.x = op[X_W-1:0];
      8'b0100_????: r.y = imm;
      8'b0101_????: r.s = (m != imm);
      8'b0110_????: begin r.mem_we = 1'b1; r.mem_d = imm; r.y = y + 4'd1; end
      8'b0111_????: r.s = (a <= imm);
      default: ;
    endcase
  end
endmodule

// File: rtl/acc4_exec_unit.sv
module acc4_exec_unit
  import acc4_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [OP_W-1:0] opcode,
  input  logic [3:0]      k_pins,
  output logic            busy,
  output logic            done,
  output logic [3:0]      acc,
  output logic [3:0]      yreg,
  output logic [1:0]      xreg,
  output logic            status,
  output logic            tdo_stb,
  output logic [3:0]      o_data,
  output logic            o_seg_mode,
  output logic            clo_stb,
  output logic            r_set_stb,
  output logic            r_clr_stb,
  output logic [3:0]      r_index
);
  phase_t          phase;
  logic [OP_W-1:0] op_q;
  nyb_t            k_q;
  nyb_t            ram_q;
  exec_res_t       alu_res;
  exec_res_t       res_q;

  assign busy    = (phase != PH_IDLE);
  assign r_index = yreg;

  acc4_nyb_ram #(.AW(ADDR_W), .DW(NYB_W)) i_ram (
    .clk   (clk),
    .we    (phase == PH_WB && res_q.mem_we),
    .addr  ({xreg, yreg}),
    .wdata (res_q.mem_d),
    .rdata (ram_q)
  );

  acc4_alu i_alu (
    .op (op_q),
    .a  (acc),
    .y  (yreg),
    .x  (xreg),
    .m  (ram_q),
    .k  (k_q),
    .r  (alu_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      op_q       <= '0;
      k_q        <= '0;
      res_q      <= '0;
      acc        <= '0;
      yreg       <= '0;
      xreg       <= '0;
      status     <= 1'b1;
      done       <= 1'b0;
      tdo_stb    <= 1'b0;
      clo_stb    <= 1'b0;
      r_set_stb  <= 1'b0;
      r_clr_stb  <= 1'b0;
      o_data     <= '0;
      o_seg_mode <= 1'b0;
    end else begin
      done      <= 1'b0;
      tdo_stb   <= 1'b0;
      clo_stb   <= 1'b0;
      r_set_stb <= 1'b0;
      r_clr_stb <= 1'b0;
      unique case (phase)
        PH_IDLE: if (start) begin
          op_q  <= opcode;
          k_q   <= k_pins;
          phase <= PH_EX;
        end
        PH_EX: begin
          res_q <= alu_res;
          phase <= PH_WB;
        end
        PH_WB: begin
          acc        <= res_q.a;
          yreg       <= res_q.y;
          xreg       <= res_q.x;
          status     <= res_q.s;
          o_data     <= acc;
          o_seg_mode <= status;
          tdo_stb    <= res_q.tdo;
          clo_stb    <= res_q.clo;
          r_set_stb  <= res_q.rset;
          r_clr_stb  <= res_q.rclr;
          done       <= 1'b1;
          phase      <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    start && !busy |=> busy) else $error("accept_chk");

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done_pulse_chk");

  // R2
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && $past(busy)) else $error("done_after_busy_chk");

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(acc) && $stable(yreg) && $stable(xreg) && $stable(status))
    else $error("hold_chk");

  // R10
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tdo_stb, clo_stb, r_set_stb, r_clr_stb})) else $error("strobe_onehot_chk");

  // R10
  strobe_done_chk: assert property (@(posedge clk) disable iff (rst)
    (tdo_stb || clo_stb || r_set_stb || r_clr_stb) |-> done) else $error("strobe_done_chk");
endmodule

// File: tb/test_acc4_exec_unit.sv
module test_acc4_exec_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] opcode = '0;
  logic [3:0] k_pins = '0;
  logic       busy, done, status, tdo_stb, o_seg_mode, clo_stb, r_set_stb, r_clr_stb;
  logic [3:0] acc, yreg, o_data, r_index;
  logic [1:0] xreg;

  int n_cmp  = 0;
  int n_bad  = 0;
  bit closed = 0;

  logic [3:0] mA, mY;
  logic [1:0] mX;
  logic       mS;
  logic [3:0] mdat [64];

  always #2 clk = ~clk;

  acc4_exec_unit i_acc4_exec_unit (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .k_pins(k_pins),
    .busy(busy), .done(done), .acc(acc), .yreg(yreg), .xreg(xreg),
    .status(status), .tdo_stb(tdo_stb), .o_data(o_data), .o_seg_mode(o_seg_mode),
    .clo_stb(clo_stb), .r_set_stb(r_set_stb), .r_clr_stb(r_clr_stb), .r_index(r_index)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(logic [7:0] op);
    if (op inside {8'h03, 8'h04, 8'h21, 8'h22, 8'h2e} || op[7:4] == 4'h6) return "R3";
    if (op inside {8'h01, 8'h05, 8'h06, 8'h0e, 8'h25, 8'h28}) return "R5";
    if (op inside {8'h07, 8'h27, 8'h2a, 8'h2c, 8'h2d}) return "R6";
    if (op inside {8'h02, 8'h26, 8'h29} || op[7:4] == 4'h5 || op[7:4] == 4'h7) return "R7";
    if (op inside {[8'h30:8'h3b]}) return "R8";
    if (op inside {8'h0a, 8'h0b, 8'h0c, 8'h0d}) return "R10";
    if (op inside {8'h08, 8'h09}) return "R11";
    if (op == 8'h0f || op[7:4] == 4'h1 || op[7]) return "R4";
    return "R9";
  endfunction

  // expected architectural effect of one instruction
  task automatic model(input logic [7:0] op, input logic [3:0] k, output logic [3:0] stb);
    int a = mA, y = mY, x = mX, s = 1, idx = mX * 16 + mY;
    int mm = mdat[idx], im = op & 15, bb = op & 3;
    bit we = 0;
    int wd = 0;
    stb = 4'b0000;
    case (op) inside
      8'h00: x = x ^ 3;
      8'h01: begin a = a + 8;  s = a > 15; end
      8'h05: begin a = a + 10; s = a > 15; end
      8'h06: begin a = a + 6;  s = a > 15; end
      8'h02: s = (y != a);
      8'h03: begin we = 1; wd = a; end
      8'h04: begin we = 1; wd = a; a = 0; end
      8'h07: begin s = a >= 1; a = a - 1; end
      8'h08: a = k;
      8'h09: s = (k != 0);
      8'h0a: stb = 4'b1000;
      8'h0b: stb = 4'b0100;
      8'h0c: stb = 4'b0001;
      8'h0d: stb = 4'b0010;
      8'h0e: a = a + 1;
      8'h20: begin we = 1; wd = a; y = y + 1; end
      8'h21: a = mm;
      8'h22: y = mm;
      8'h23: a = y;
      8'h24: y = a;
      8'h25: begin a = a + mm; s = a > 15; end
      8'h26: s = (mm != 0);
      8'h27: begin s = mm >= a; a = mm - a; end
      8'h28: begin a = mm + 1; s = a > 15; end
      8'h29: s = (a <= mm);
      8'h2a: begin s = mm >= 1; a = mm - 1; end
      8'h2b: begin y = y + 1; s = y > 15; end
      8'h2c: begin s = y >= 1; y = y - 1; end
      8'h2d: begin s = (a == 0); a = -a; end
      8'h2e: begin we = 1; wd = a; a = mm; end
      8'h2f: a = 0;
      [8'h30:8'h33]: begin we = 1; wd = mm | (1 << bb); end
      [8'h34:8'h37]: begin we = 1; wd = mm & ~(1 << bb); end
      [8'h38:8'h3b]: s = (mm >> bb) & 1;
      [8'h3c:8'h3f]: x = bb;
      [8'h40:8'h4f]: y = im;
      [8'h50:8'h5f]: s = (mm != im);
      [8'h60:8'h6f]: begin we = 1; wd = im; y = y + 1; end
      [8'h70:8'h7f]: s = (a <= im);
      default: ;
    endcase
    if (we) mdat[idx] = 4'(wd);
    mA = 4'(a);
    mY = 4'(y);
    mX = 2'(x);
    mS = s[0];
  endtask

  task automatic run(input logic [7:0] op, input logic [3:0] k, input bit disturb);
    logic [3:0] stb;
    logic [3:0] preA, preY;
    logic       preS;
    string      t;
    t    = tag_of(op);
    preA = mA;
    preY = mY;
    preS = mS;
    @(negedge clk);
    opcode = op;
    k_pins = k;
    start  = 1'b1;
    model(op, k, stb);
    @(negedge clk);
    start  = disturb;
    opcode = ~op;
    k_pins = ~k;
    @(negedge clk);
    start = 1'b0;
    chk("R2", "busy mid", busy, 1);
    chk("R2", "done early", done, 0);
    @(negedge clk);
    chk("R2", "done", done, 1);
    chk("R2", "busy after", busy, 0);
    chk(t, "acc", acc, mA);
    chk(t, "y", yreg, mY);
    chk(t, "x", xreg, mX);
    chk(t, "status", status, mS);
    // R10 strobe pattern {tdo,clo,set,clr}
    chk("R10", "strobes", {tdo_stb, clo_stb, r_set_stb, r_clr_stb}, stb);
    if (stb[3]) begin
      chk("R10", "o_data", o_data, preA);
      chk("R10", "o_seg_mode", o_seg_mode, preS);
    end
    if (stb[1] || stb[0]) chk("R10", "r_index", r_index, preY);
  endtask

  initial begin
    #(4 * 190000);
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    if (!closed) begin
      closed = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    mA = 0; mY = 0; mX = 0; mS = 1;
    for (int i = 0; i < 64; i++) mdat[i] = 0;
    repeat (3) @(negedge clk);
    // R1 values held during reset
    chk("R1", "acc in reset", acc, 0);
    chk("R1", "status in reset", status, 1);
    rst = 1'b0;
    @(negedge clk);
    // R1 values after release
    chk("R1", "acc", acc, 0);
    chk("R1", "y", yreg, 0);
    chk("R1", "x", xreg, 0);
    chk("R1", "status", status, 1);
    chk("R1", "busy/done", {busy, done}, 0);
    chk("R1", "strobes", {tdo_stb, clo_stb, r_set_stb, r_clr_stb}, 0);

    // R3 fill every word through X loads and store-and-increment
    for (int x = 0; x < 4; x++) begin
      run(8'h3c | 8'(x), 4'h0, 0);
      run(8'h40, 4'h0, 0);
      for (int i = 0; i < 16; i++) run(8'h60 | 8'((x * 5 + i * 3) & 15), 4'h0, 0);
    end
    // R3 read back words (X=1,Y=8 etc.)
    run(8'h3d, 0, 0); run(8'h48, 0, 0); run(8'h21, 0, 0);
    run(8'h3f, 0, 0); run(8'h4f, 0, 0); run(8'h22, 0, 0);

    // R5 carry edge: A=8 + 8
    run(8'h48, 0, 0); run(8'h23, 0, 0); run(8'h01, 0, 0);
    run(8'h47, 0, 0); run(8'h23, 0, 0); run(8'h01, 0, 0);
    run(8'h4f, 0, 0); run(8'h23, 0, 0); run(8'h0e, 0, 0);
    // R6 borrow edges: A=0 minus 1, Y=0 minus 1, negate zero
    run(8'h2f, 0, 0); run(8'h07, 0, 0); run(8'h07, 0, 0);
    run(8'h40, 0, 0); run(8'h2c, 0, 0); run(8'h2c, 0, 0);
    run(8'h2f, 0, 0); run(8'h2d, 0, 0); run(8'h2d, 0, 0);
    // R9 Y wrap with carry
    run(8'h4f, 0, 0); run(8'h2b, 0, 0); run(8'h2b, 0, 0);
    // R7 A equal to immediate and one above
    run(8'h45, 0, 0); run(8'h23, 0, 0); run(8'h75, 0, 0); run(8'h74, 0, 0);
    // R8 bit ops on one word
    run(8'h3c, 0, 0); run(8'h40, 0, 0); run(8'h30, 0, 0); run(8'h33, 0, 0);
    run(8'h38, 0, 0); run(8'h39, 0, 0); run(8'h34, 0, 0); run(8'h38, 0, 0);
    // R11 K zero/non-zero, changed after acceptance
    run(8'h09, 4'h0, 1); run(8'h09, 4'h8, 1); run(8'h08, 4'ha, 1);
    // R10 output with status 0 then 1
    run(8'h40, 0, 0); run(8'h2c, 0, 0); run(8'h0a, 0, 0); run(8'h0a, 0, 0);
    run(8'h0c, 0, 0); run(8'h0d, 0, 0); run(8'h0b, 0, 0);
    // R4 no-effect opcodes
    run(8'h0f, 0, 0); run(8'h1a, 0, 0); run(8'h95, 0, 0); run(8'hc3, 0, 0);

    for (int n = 0; n < 500; n++) begin
      logic [7:0] op;
      op = 8'($urandom);
      if (op[7] && ($urandom % 4 != 0)) op[7] = 1'b0;
      run(op, 4'($urandom), bit'($urandom % 2));
    end

    closed = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule